// File: doc/BRIEF.md
# Parallel Host to Serial Queue Bridge

This block is the device-side controller of a bridge between an 8-bit parallel host port and serial transmit and receive queues. The host owns one active-low strobe, a direction bit, a data/status select bit and a DTR line. The bridge returns two flags: one says that the transmit queue can take a byte, and the other says that the receive queue holds a byte. Each strobe cycle is one byte transfer. The direction and select bits decide what that transfer is: a push into the transmit queue, a pop from the receive queue, a read of the modem status byte, or a write of the port and speed configuration.

All host control inputs pass through a two-flop synchronizer. An access happens once per strobe, on the falling edge of the synchronized strobe. The serial side is modelled as plain FIFO interfaces. Serializers and line drivers sit outside the block. The port number and speed code are held in registers and exposed, together with the baud rate that the speed code selects. The host DTR level is routed to the DTR output of the selected port only.

The data bus is split into an input, an output and an output enable, so that a pad wrapper can build the bidirectional pins.

Top module: `par_uart_bridge`

## Requirements
- R1: Each falling edge of the synchronized strobe performs exactly one access, and holding the strobe low performs no further access. The access kind is decoded from direction and select: dir=0,sel=1 pushes, dir=1,sel=1 pops, dir=1,sel=0 reads status, and dir=0,sel=0 writes configuration.
- R2: `host_cts` is 1 exactly when the transmit FIFO is not full.
- R3: `host_dwait` is 1 exactly when the receive FIFO holds at least one byte.
- R4: `host_data_oe` is 1 only while the synchronized direction is 1 (read) and the synchronized strobe is 0. It is 0 during writes and while the strobe is idle.
- R5: A data write places `host_data_in` into the transmit FIFO. The bytes leave on `tx_data` in write order, and `tx_data` shows the head while `tx_avail` is 1.
- R6: A data read drives the oldest receive byte on `host_data_out` and removes it. A read from an empty receive FIFO returns 0x00 and leaves the FIFO empty.
- R7: A data write while the transmit FIFO is full is ignored, and the stored bytes are unchanged.
- R8: A status read returns, for the selected port, DCD on bit 0, DTR on bit 1, DSR on bit 2, RTS on bit 3, CTS on bit 4 and RI on bit 5, with bits 7:6 zero. A port number at or above NPORTS reads 0x00.
- R9: A configuration write loads the port number from bits 3:0 and the speed code from bits 7:4. Speed codes 0..8 select 300, 1200, 2400, 4800, 9600, 19200, 38400, 57600 and 115200 baud in that order, shown on `cfg_baud`.
- R10: A configuration write with a speed code above 8 keeps the previous speed code but still loads the port number.
- R11: `port_dtr` carries the synchronized host DTR on the bit of the selected port, and all other bits are 0.
- R12: After reset the port is 0, the speed code is 4 (9600 baud), both FIFOs are empty, `host_cts` is 1, `host_dwait` is 0 and `host_data_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_strobe_n | input | 1 | Host strobe, low during a transfer |
| host_dir | input | 1 | 0 = host writes, 1 = host reads |
| host_sel | input | 1 | 1 = FIFO data, 0 = status/configuration |
| host_dtr | input | 1 | Host DTR level |
| host_data_in | input | 8 | Data bus as driven by the host |
| host_data_out | output | 8 | Data bus value driven by the bridge |
| host_data_oe | output | 1 | Bridge drives the data bus |
| host_cts | output | 1 | Transmit FIFO not full |
| host_dwait | output | 1 | Receive FIFO not empty |
| tx_pop | input | 1 | Serial side takes the transmit head |
| tx_data | output | 8 | Transmit FIFO head |
| tx_avail | output | 1 | Transmit FIFO not empty |
| rx_push | input | 1 | Serial side delivers a byte |
| rx_data | input | 8 | Received byte |
| rx_full | output | 1 | Receive FIFO full |
| mdm_dcd | input | NPORTS | Carrier detect per port |
| mdm_dsr | input | NPORTS | Data set ready per port |
| mdm_rts | input | NPORTS | Request to send per port |
| mdm_cts | input | NPORTS | Clear to send per port |
| mdm_ri | input | NPORTS | Ring indicator per port |
| port_dtr | output | NPORTS | DTR to each port |
| cfg_port | output | 4 | Selected port number |
| cfg_speed | output | 4 | Selected speed code |
| cfg_baud | output | 17 | Baud rate of the speed code |

## Verification
The assertions check on every cycle that a strobe edge never decodes into more than one access, and that the bus enable follows a strobe-low read seen three cycles earlier at the pins. They also check that the flags fall or rise only after the event that could cause the change, that a full or empty FIFO never moves on a rejected access, that the speed code stays in range, and that DTR reaches at most one port. The data values are checked only by the bench's scenarios: the FIFO ordering, the 0x00 returned by an empty read, the status bit layout per port, the rate table, and the retention of the speed setting on an invalid code.

// File: rtl/bridge_pkg.sv
// Shared constants for the parallel-to-serial bridge: field widths,
// status bit positions and the speed-code to baud-rate mapping.
package bridge_pkg;
    localparam int PORT_W    = 4;
    localparam int SPEED_W   = 4;
    localparam int BAUD_W    = 17;
    localparam int SPEED_MAX = 8;
    localparam int SPEED_RST = 4;

    localparam int ST_DCD = 0;
    localparam int ST_DTR = 1;
    localparam int ST_DSR = 2;
    localparam int ST_RTS = 3;
    localparam int ST_CTS = 4;
    localparam int ST_RI  = 5;

    // Maps a valid speed code to its rate; invalid codes map to zero.
    function automatic logic [BAUD_W-1:0] speed_to_baud(input logic [SPEED_W-1:0] code);
        logic [BAUD_W-1:0] rate;
        case (code)
            4'd0:    rate = BAUD_W'(300);
            4'd1:    rate = BAUD_W'(1200);
            4'd2:    rate = BAUD_W'(2400);
            4'd3:    rate = BAUD_W'(4800);
            4'd4:    rate = BAUD_W'(9600);
            4'd5:    rate = BAUD_W'(19200);
            4'd6:    rate = BAUD_W'(38400);
            4'd7:    rate = BAUD_W'(57600);
            4'd8:    rate = BAUD_W'(115200);
            default: rate = '0;
        endcase
        return rate;
    endfunction
endpackage

// File: rtl/bridge_sync.sv
// Two-flop synchronizer for a bundle of asynchronous level inputs.
// Assumes each bit is independent and can be resolved one bit at a time.
// The reset value is chosen so that idle levels are seen during reset.
module bridge_sync #(
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1;

    // Two register stages that resolve metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= RST_VAL;
            sync_out <= RST_VAL;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/bridge_fifo.sv
// Synchronous show-ahead FIFO. The head word is on rd_data whenever
// the FIFO is not empty. A push while full and a pop while empty are
// dropped here, so callers need not guard them.
module bridge_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             pop,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rd_data = mem[rd_ptr];

    // Advances a pointer and wraps it at DEPTH.
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // Storage write. It has no reset because the contents are guarded by count.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wr_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R7: a push into a full FIFO without a pop changes nothing
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && $stable(count)));

    // R6: a pop from an empty FIFO without a push leaves it empty
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);
endmodule

// File: rtl/bridge_cfg.sv
// Port/speed configuration register, DTR routing and status byte mux.
// Assumes that wr is a single-cycle pulse from the strobe decoder and
// that the modem inputs are already synchronous or slow enough to sample.
module bridge_cfg
    import bridge_pkg::*;
#(
    parameter int NPORTS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [7:0]         wdata,
    input  logic               dtr_in,
    input  logic [NPORTS-1:0]  mdm_dcd,
    input  logic [NPORTS-1:0]  mdm_dsr,
    input  logic [NPORTS-1:0]  mdm_rts,
    input  logic [NPORTS-1:0]  mdm_cts,
    input  logic [NPORTS-1:0]  mdm_ri,
    output logic [NPORTS-1:0]  port_dtr,
    output logic [PORT_W-1:0]  cfg_port,
    output logic [SPEED_W-1:0] cfg_speed,
    output logic [BAUD_W-1:0]  cfg_baud,
    output logic [7:0]         status
);
    logic [PORT_W-1:0]  new_port;
    logic [SPEED_W-1:0] new_speed;

    assign new_port  = wdata[PORT_W-1:0];
    assign new_speed = wdata[PORT_W +: SPEED_W];

    // Configuration register; an out-of-range speed code keeps the old one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_port  <= '0;
            cfg_speed <= SPEED_W'(SPEED_RST);
            cfg_baud  <= speed_to_baud(SPEED_W'(SPEED_RST));
        end else if (wr) begin
            cfg_port <= new_port;
            if (new_speed <= SPEED_W'(SPEED_MAX)) begin
                cfg_speed <= new_speed;
                cfg_baud  <= speed_to_baud(new_speed);
            end
        end
    end

    // DTR is routed only to the selected port.
    for (genvar g = 0; g < NPORTS; g++) begin : g_dtr
        assign port_dtr[g] = dtr_in && (cfg_port == PORT_W'(g));
    end

    // Builds the status byte of the selected port; out of range reads zero.
    always_comb begin
        status = '0;
        for (int i = 0; i < NPORTS; i++) begin
            if (cfg_port == PORT_W'(i)) begin
                status[ST_DCD] = mdm_dcd[i];
                status[ST_DTR] = port_dtr[i];
                status[ST_DSR] = mdm_dsr[i];
                status[ST_RTS] = mdm_rts[i];
                status[ST_CTS] = mdm_cts[i];
                status[ST_RI]  = mdm_ri[i];
            end
        end
    end

    // R10: the speed code never leaves the valid range
    p_speed_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_speed <= SPEED_W'(SPEED_MAX));

    // R11: DTR reaches at most one port
    p_dtr_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_dtr));
endmodule

// File: rtl/par_uart_bridge.sv
// Top of the parallel-host to serial-queue bridge. It synchronizes the
// host controls, detects the strobe falling edge, decodes the access kind
// and steers the transmit FIFO, receive FIFO, status byte and
// configuration register. Assumes that the host data is stable from
// before the strobe falls until it rises.
module par_uart_bridge
    import bridge_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int NPORTS     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_strobe_n,
    input  logic               host_dir,
    input  logic               host_sel,
    input  logic               host_dtr,
    input  logic [7:0]         host_data_in,
    output logic [7:0]         host_data_out,
    output logic               host_data_oe,
    output logic               host_cts,
    output logic               host_dwait,
    input  logic               tx_pop,
    output logic [7:0]         tx_data,
    output logic               tx_avail,
    input  logic               rx_push,
    input  logic [7:0]         rx_data,
    output logic               rx_full,
    input  logic [NPORTS-1:0]  mdm_dcd,
    input  logic [NPORTS-1:0]  mdm_dsr,
    input  logic [NPORTS-1:0]  mdm_rts,
    input  logic [NPORTS-1:0]  mdm_cts,
    input  logic [NPORTS-1:0]  mdm_ri,
    output logic [NPORTS-1:0]  port_dtr,
    output logic [PORT_W-1:0]  cfg_port,
    output logic [SPEED_W-1:0] cfg_speed,
    output logic [BAUD_W-1:0]  cfg_baud
);
    // Synchronized control bundle: {strobe_n, dir, sel, dtr}
    logic [3:0] ctl_s;
    logic       stb_s, dir_s, sel_s, dtr_s;
    logic       stb_q, stb_fall;
    logic       tx_push_evt, rx_pop_evt, cfg_wr_evt, stat_rd_evt;
    logic       tx_empty, tx_full, rx_empty;
    logic [7:0] rx_head, status, rd_q;
    logic       oe_q;

    bridge_sync #(.W(4), .RST_VAL(4'b1010)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({host_strobe_n, host_dir, host_sel, host_dtr}),
        .sync_out (ctl_s)
    );

    assign {stb_s, dir_s, sel_s, dtr_s} = ctl_s;

    // Previous synchronized strobe, for the falling-edge detect.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b1;
        else        stb_q <= stb_s;
    end

    assign stb_fall    = stb_q && !stb_s;
    assign tx_push_evt = stb_fall && !dir_s &&  sel_s;
    assign rx_pop_evt  = stb_fall &&  dir_s &&  sel_s;
    assign stat_rd_evt = stb_fall &&  dir_s && !sel_s;
    assign cfg_wr_evt  = stb_fall && !dir_s && !sel_s;

    bridge_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (tx_push_evt),
        .wr_data (host_data_in),
        .pop     (tx_pop),
        .rd_data (tx_data),
        .empty   (tx_empty),
        .full    (tx_full)
    );

    bridge_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (rx_push),
        .wr_data (rx_data),
        .pop     (rx_pop_evt),
        .rd_data (rx_head),
        .empty   (rx_empty),
        .full    (rx_full)
    );

    bridge_cfg #(.NPORTS(NPORTS)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cfg_wr_evt),
        .wdata     (host_data_in),
        .dtr_in    (dtr_s),
        .mdm_dcd   (mdm_dcd),
        .mdm_dsr   (mdm_dsr),
        .mdm_rts   (mdm_rts),
        .mdm_cts   (mdm_cts),
        .mdm_ri    (mdm_ri),
        .port_dtr  (port_dtr),
        .cfg_port  (cfg_port),
        .cfg_speed (cfg_speed),
        .cfg_baud  (cfg_baud),
        .status    (status)
    );

    // Read register: captures the popped byte or the status snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n)           rd_q <= '0;
        else if (rx_pop_evt)  rd_q <= rx_empty ? 8'h00 : rx_head;
        else if (stat_rd_evt) rd_q <= status;
    end

    // Bus enable, registered so that it becomes valid together with rd_q.
    always_ff @(posedge clk) begin
        if (!rst_n) oe_q <= 1'b0;
        else        oe_q <= dir_s && !stb_s;
    end

    assign host_data_out = rd_q;
    assign host_data_oe  = oe_q;
    assign host_cts      = !tx_full;
    assign host_dwait    = !rx_empty;
    assign tx_avail      = !tx_empty;

    // R1: one strobe edge decodes to at most one access
    p_one_access_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_push_evt, rx_pop_evt, stat_rd_evt, cfg_wr_evt}));

    // R2: clear-to-send drops only after a host write
    p_cts_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_cts) |-> $past(tx_push_evt));

    // R3: data-waiting rises only after a serial-side delivery
    p_dwait_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_dwait) |-> $past(rx_push));

    // R6: data-waiting falls only after a host data read
    p_dwait_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_dwait) |-> $past(rx_pop_evt));

    // R4: the bus is driven only for a strobe-low read seen three cycles earlier
    p_oe_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        host_data_oe |-> (!$past(host_strobe_n, 3) && $past(host_dir, 3)));
endmodule

// File: tb/par_uart_bridge_tb.sv
// Directed bench for the bridge: one task per scenario, each checking
// its own results against values derived from the requirements.
module par_uart_bridge_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int NP         = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           host_strobe_n = 1'b1;
    logic           host_dir = 1'b0;
    logic           host_sel = 1'b1;
    logic           host_dtr = 1'b0;
    logic [7:0]     host_data_in = '0;
    logic [7:0]     host_data_out;
    logic           host_data_oe, host_cts, host_dwait;
    logic           tx_pop = 1'b0;
    logic [7:0]     tx_data;
    logic           tx_avail;
    logic           rx_push = 1'b0;
    logic [7:0]     rx_data = '0;
    logic           rx_full;
    logic [NP-1:0]  mdm_dcd = '0, mdm_dsr = '0, mdm_rts = '0, mdm_cts = '0, mdm_ri = '0;
    logic [NP-1:0]  port_dtr;
    logic [3:0]     cfg_port, cfg_speed;
    logic [16:0]    cfg_baud;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    par_uart_bridge #(.FIFO_DEPTH(DEPTH), .NPORTS(NP)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_strobe_n(host_strobe_n), .host_dir(host_dir), .host_sel(host_sel),
        .host_dtr(host_dtr), .host_data_in(host_data_in),
        .host_data_out(host_data_out), .host_data_oe(host_data_oe),
        .host_cts(host_cts), .host_dwait(host_dwait),
        .tx_pop(tx_pop), .tx_data(tx_data), .tx_avail(tx_avail),
        .rx_push(rx_push), .rx_data(rx_data), .rx_full(rx_full),
        .mdm_dcd(mdm_dcd), .mdm_dsr(mdm_dsr), .mdm_rts(mdm_rts),
        .mdm_cts(mdm_cts), .mdm_ri(mdm_ri), .port_dtr(port_dtr),
        .cfg_port(cfg_port), .cfg_speed(cfg_speed), .cfg_baud(cfg_baud)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One full strobe cycle; returns the bus value and enable seen mid-strobe.
    task automatic host_access(input logic dir, input logic sel, input logic [7:0] wd,
                               output logic [7:0] rd, output logic oe_mid);
        @(negedge clk);
        host_dir     = dir;
        host_sel     = sel;
        host_data_in = wd;
        wait_cycles(3);
        host_strobe_n = 1'b0;
        wait_cycles(6);
        rd     = host_data_out;
        oe_mid = host_data_oe;
        host_strobe_n = 1'b1;
        wait_cycles(6);
    endtask

    task automatic host_write(input logic [7:0] wd);
        logic [7:0] r; logic o;
        host_access(1'b0, 1'b1, wd, r, o);
    endtask

    task automatic cfg_write(input logic [7:0] wd);
        logic [7:0] r; logic o;
        host_access(1'b0, 1'b0, wd, r, o);
    endtask

    task automatic serial_push(input logic [7:0] d);
        @(negedge clk);
        rx_data = d; rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic serial_pop();
        @(negedge clk);
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    function automatic logic [16:0] exp_baud(input int code);
        case (code)
            0: return 17'd300;     1: return 17'd1200;   2: return 17'd2400;
            3: return 17'd4800;    4: return 17'd9600;   5: return 17'd19200;
            6: return 17'd38400;   7: return 17'd57600;  default: return 17'd115200;
        endcase
    endfunction

    task automatic t_reset();
        chk("R12 port", 32'(cfg_port), 0);
        chk("R12 speed", 32'(cfg_speed), 4);
        chk("R12 baud", 32'(cfg_baud), 9600);
        chk("R12 cts", 32'(host_cts), 1);
        chk("R12 dwait", 32'(host_dwait), 0);
        chk("R12 oe", 32'(host_data_oe), 0);
        chk("R12 tx empty", 32'(tx_avail), 0);
        chk("R12 rx not full", 32'(rx_full), 0);
    endtask

    task automatic t_oe_idle();
        logic [7:0] r; logic o;
        @(negedge clk);
        host_dir = 1'b1;
        wait_cycles(6);
        chk("R4 idle read dir", 32'(host_data_oe), 0);
        host_access(1'b0, 1'b1, 8'h11, r, o);
        chk("R4 oe during write", 32'(o), 0);
        serial_pop();
        chk("R5 single byte drained", 32'(tx_avail), 0);
    endtask

    task automatic t_write_order();
        host_write(8'hA5);
        host_write(8'h3C);
        host_write(8'hF0);
        chk("R5 head 0", 32'(tx_data), 32'h A5);
        serial_pop();
        chk("R5 head 1", 32'(tx_data), 32'h3C);
        serial_pop();
        chk("R5 head 2", 32'(tx_data), 32'hF0);
        serial_pop();
        chk("R1 one push per strobe", 32'(tx_avail), 0);
    endtask

    task automatic t_tx_full();
        for (int i = 0; i < DEPTH; i++) host_write(8'(8'h40 + i));
        chk("R2 cts low when full", 32'(host_cts), 0);
        host_write(8'hEE);
        for (int i = 0; i < DEPTH; i++) begin
            chk("R7 content kept", 32'(tx_data), 32'(8'h40 + i));
            serial_pop();
        end
        chk("R7 extra byte dropped", 32'(tx_avail), 0);
        chk("R2 cts high again", 32'(host_cts), 1);
    endtask

    task automatic t_read();
        logic [7:0] r; logic o;
        serial_push(8'h5A);
        serial_push(8'hC3);
        chk("R3 dwait set", 32'(host_dwait), 1);
        host_access(1'b1, 1'b1, 8'h00, r, o);
        chk("R6 first byte", 32'(r), 32'h5A);
        chk("R4 oe during read", 32'(o), 1);
        host_access(1'b1, 1'b1, 8'h00, r, o);
        chk("R6 second byte", 32'(r), 32'hC3);
        chk("R3 dwait clear", 32'(host_dwait), 0);
        chk("R4 oe after strobe", 32'(host_data_oe), 0);
        host_access(1'b1, 1'b1, 8'h00, r, o);
        chk("R6 empty read", 32'(r), 0);
        chk("R6 stays empty", 32'(host_dwait), 0);
        serial_push(8'h77);
        host_access(1'b1, 1'b1, 8'h00, r, o);
        chk("R6 no underflow", 32'(r), 32'h77);
    endtask

    task automatic t_config();
        for (int c = 0; c <= 8; c++) begin
            cfg_write(8'((c << 4) | 1));
            chk("R9 speed code", 32'(cfg_speed), 32'(c));
            chk("R9 baud", 32'(cfg_baud), 32'(exp_baud(c)));
        end
        chk("R9 port", 32'(cfg_port), 1);
        cfg_write(8'h93);
        chk("R10 port loaded", 32'(cfg_port), 3);
        chk("R10 speed kept", 32'(cfg_speed), 8);
        cfg_write(8'hF2);
        chk("R10 speed kept F", 32'(cfg_speed), 8);
        chk("R10 baud kept", 32'(cfg_baud), 115200);
    endtask

    task automatic t_status_dtr();
        logic [7:0] r; logic o;
        mdm_dcd = 4'b0101; mdm_dsr = 4'b0100; mdm_rts = 4'b0001;
        mdm_cts = 4'b0100; mdm_ri  = 4'b0001;
        host_dtr = 1'b1;
        cfg_write(8'h20);
        chk("R11 dtr port 0", 32'(port_dtr), 32'b0001);
        host_access(1'b1, 1'b0, 8'h00, r, o);
        chk("R8 status port 0", 32'(r), 32'b0010_1011);
        cfg_write(8'h22);
        chk("R11 dtr port 2", 32'(port_dtr), 32'b0100);
        host_access(1'b1, 1'b0, 8'h00, r, o);
        chk("R8 status port 2", 32'(r), 32'b0001_0111);
        chk("R1 status read leaves rx", 32'(host_dwait), 0);
        host_dtr = 1'b0;
        wait_cycles(4);
        chk("R11 dtr follows host", 32'(port_dtr), 0);
        host_dtr = 1'b1;
        cfg_write(8'h29);
        chk("R11 out of range port", 32'(port_dtr), 0);
        host_access(1'b1, 1'b0, 8'h00, r, o);
        chk("R8 out of range status", 32'(r), 0);
    endtask

    initial begin
        wait_cycles(4);
        rst_n = 1'b1;
        wait_cycles(2);
        t_reset();
        t_oe_idle();
        t_write_order();
        t_tx_full();
        t_read();
        t_config();
        t_status_dtr();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule